// File: doc/BRIEF.md
# Lockable SMI Enable Register

This block holds the enable bits for System Management Interrupts in a single control register whose writes pass through a per-bit write mask. The mask opens every bit at reset. A second register, reached through a separate configuration port, carries a lock bit. Once software sets the lock, the mask closes over the global SMI enable bit and the lock bit becomes sticky. Both stay frozen until the next reset, while every other bit of both registers stays writable.

Firmware programs the enables during early boot, sets the lock, and from then on nothing outside a reset can switch the global enable on or off. Both registers are read through single-cycle ports. A read strobe returns the stored value one cycle later. The current enable bits and the lock state are also driven out continuously.

Top module: `smi_lock_ctrl`

## Requirements
- R1: After reset the enable register equals parameter EN_RST, every configuration bit is 0, and lock_o is 0.
- R2: While lock_o is 0, a write to the enable register stores every bit of en_wdata, including bit GBL_BIT (the global enable), so the write mask is fully open.
- R3: A configuration write with cfg_wdata[LOCK_BIT] = 1 sets the lock bit, and lock_o is 1 from the cycle after that write.
- R4: While lock_o is 1, writes to the enable register leave bit GBL_BIT unchanged, whether they try to set it or clear it.
- R5: While lock_o is 1, a configuration write with cfg_wdata[LOCK_BIT] = 0 leaves the lock bit at 1. The other configuration bits still take the written value.
- R6: Enable bits other than GBL_BIT take the written value on every enable write, locked or not.
- R7: An enable write in the same cycle as the configuration write that sets the lock uses the open mask, so bit GBL_BIT takes the written value. The closed mask applies from the next cycle.
- R8: A read strobe (en_re or cfg_re) in cycle t raises the matching rvalid in cycle t+1, with rdata equal to the full stored value at cycle t. That value ignores any write in the same cycle and does not depend on the mask.
- R9: A configuration write with cfg_wdata[LOCK_BIT] = 0 while the lock is clear leaves it clear.
- R10: Only reset clears the lock. After a reset, bit GBL_BIT is writable again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | EN_W | Enable register write data |
| en_re | input | 1 | Enable register read strobe |
| en_rvalid | output | 1 | Enable read data valid (one cycle after en_re) |
| en_rdata | output | EN_W | Enable register read data |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | CFG_W | Configuration register write data |
| cfg_re | input | 1 | Configuration register read strobe |
| cfg_rvalid | output | 1 | Configuration read data valid |
| cfg_rdata | output | CFG_W | Configuration register read data, lock bit at LOCK_BIT |
| smi_en_o | output | EN_W | Current enable bits |
| lock_o | output | 1 | Current lock state |

## Verification
The bench builds the block with EN_W = 16, GBL_BIT = 3, CFG_W = 8 and LOCK_BIT = 2. Neither position is bit 0, so a design that hard-codes the frozen bit or the lock bit at the low end is caught. Write patterns set and clear bits on both sides of the global bit, which separates the frozen bit from its still-writable neighbours. One cycle carries both the lock-setting configuration write and an enable write, to check the open mask in that cycle. A reset in the middle of the run shows the lock and the mask reopening.

// File: rtl/smi_lock_pkg.sv
package smi_lock_pkg;

    typedef enum logic {
        LOCK_OPEN   = 1'b0,
        LOCK_CLOSED = 1'b1
    } lock_state_e;

    // One-hot vector of width w with bit idx set
    function automatic logic [63:0] onehot64(input int idx);
        logic [63:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/smi_rd_port.sv
module smi_rd_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         re,
    input  logic [W-1:0] src,
    output logic         rvalid,
    output logic [W-1:0] rdata
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } rd_state_t;

    rd_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = re;
        if (re) begin
            s_d.data = src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rvalid = s_q.vld;
    assign rdata  = s_q.data;

endmodule

// File: rtl/smi_lock_cfg.sv
module smi_lock_cfg
    import smi_lock_pkg::*;
#(
    parameter int CFG_W    = 8,
    parameter int LOCK_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_o,
    output logic             lock_o,
    output logic             lock_nx_o
);

    localparam logic [CFG_W-1:0] LOCK_SEL = CFG_W'(onehot64(LOCK_BIT));

    typedef struct packed {
        lock_state_e      st;
        logic [CFG_W-1:0] other;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            // ordinary bits follow the write; lock position kept clear
            s_d.other = wdata & ~LOCK_SEL;
            // lock is set-only: a 1 closes it, a 0 changes nothing
            if (wdata[LOCK_BIT]) begin
                s_d.st = LOCK_CLOSED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: LOCK_OPEN, other: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign lock_o    = (s_q.st == LOCK_CLOSED);
    assign lock_nx_o = (s_d.st == LOCK_CLOSED);
    assign cfg_o     = s_q.other | (lock_o ? LOCK_SEL : '0);

endmodule

// File: rtl/smi_wmask.sv
module smi_wmask
    import smi_lock_pkg::*;
#(
    parameter int EN_W    = 32,
    parameter int GBL_BIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock_nx,
    output logic [EN_W-1:0] mask_o
);

    localparam logic [EN_W-1:0] FROZEN = EN_W'(onehot64(GBL_BIT));

    typedef struct packed {
        logic [EN_W-1:0] mask;
    } mask_state_t;

    mask_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // closing only; the mask reopens through reset alone
        if (lock_nx) begin
            s_d.mask = s_q.mask & ~FROZEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask_o = s_q.mask;

endmodule

// File: rtl/smi_en_reg.sv
module smi_en_reg #(
    parameter int              EN_W   = 32,
    parameter logic [EN_W-1:0] EN_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [EN_W-1:0] wdata,
    input  logic [EN_W-1:0] mask,
    output logic [EN_W-1:0] en_o
);

    typedef struct packed {
        logic [EN_W-1:0] en;
    } en_state_t;

    en_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.en = (s_q.en & ~mask) | (wdata & mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en <= EN_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o = s_q.en;

endmodule

// File: rtl/smi_lock_ctrl.sv
module smi_lock_ctrl #(
    parameter int              EN_W     = 32,
    parameter int              GBL_BIT  = 0,
    parameter logic [EN_W-1:0] EN_RST   = '0,
    parameter int              CFG_W    = 8,
    parameter int              LOCK_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic [EN_W-1:0]  en_wdata,
    input  logic             en_re,
    output logic             en_rvalid,
    output logic [EN_W-1:0]  en_rdata,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cfg_re,
    output logic             cfg_rvalid,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [EN_W-1:0]  smi_en_o,
    output logic             lock_o
);

    logic [CFG_W-1:0] cfg_val;
    logic             lock_nx;
    logic [EN_W-1:0]  wmask;

    smi_lock_cfg #(
        .CFG_W   (CFG_W),
        .LOCK_BIT(LOCK_BIT)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .cfg_o    (cfg_val),
        .lock_o   (lock_o),
        .lock_nx_o(lock_nx)
    );

    smi_wmask #(
        .EN_W   (EN_W),
        .GBL_BIT(GBL_BIT)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_nx(lock_nx),
        .mask_o (wmask)
    );

    smi_en_reg #(
        .EN_W  (EN_W),
        .EN_RST(EN_RST)
    ) u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (en_we),
        .wdata(en_wdata),
        .mask (wmask),
        .en_o (smi_en_o)
    );

    smi_rd_port #(.W(EN_W)) u_en_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .re    (en_re),
        .src   (smi_en_o),
        .rvalid(en_rvalid),
        .rdata (en_rdata)
    );

    smi_rd_port #(.W(CFG_W)) u_cfg_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .re    (cfg_re),
        .src   (cfg_val),
        .rvalid(cfg_rvalid),
        .rdata (cfg_rdata)
    );

endmodule

// File: rtl/smi_lock_chk.sv
module smi_lock_chk
    import smi_lock_pkg::*;
#(
    parameter int              EN_W     = 32,
    parameter int              GBL_BIT  = 0,
    parameter logic [EN_W-1:0] EN_RST   = '0,
    parameter int              CFG_W    = 8,
    parameter int              LOCK_BIT = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_we,
    input logic [EN_W-1:0]  en_wdata,
    input logic             en_re,
    input logic             en_rvalid,
    input logic [EN_W-1:0]  en_rdata,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             cfg_re,
    input logic             cfg_rvalid,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic [EN_W-1:0]  smi_en_o,
    input logic             lock_o
);

    localparam logic [EN_W-1:0] OPEN_BITS = ~EN_W'(onehot64(GBL_BIT));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!lock_o && smi_en_o == EN_RST));

    // R2
    open_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && en_we) |=> smi_en_o == $past(en_wdata));

    // R3
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[LOCK_BIT]) |=> lock_o);

    // R4
    gbl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && en_we) |=> $stable(smi_en_o[GBL_BIT]));

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);

    // R6
    open_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> ((smi_en_o ^ $past(en_wdata)) & OPEN_BITS) == '0);

    // R8
    en_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_re |=> (en_rvalid && en_rdata == $past(smi_en_o)));

    // R8
    cfg_read_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_re |=> (cfg_rvalid && cfg_rdata[LOCK_BIT] == $past(lock_o)));

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && cfg_we && !cfg_wdata[LOCK_BIT]) |=> !lock_o);

endmodule

bind smi_lock_ctrl smi_lock_chk #(
    .EN_W    (EN_W),
    .GBL_BIT (GBL_BIT),
    .EN_RST  (EN_RST),
    .CFG_W   (CFG_W),
    .LOCK_BIT(LOCK_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_we     (en_we),
    .en_wdata  (en_wdata),
    .en_re     (en_re),
    .en_rvalid (en_rvalid),
    .en_rdata  (en_rdata),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_re    (cfg_re),
    .cfg_rvalid(cfg_rvalid),
    .cfg_rdata (cfg_rdata),
    .smi_en_o  (smi_en_o),
    .lock_o    (lock_o)
);

// File: tb/smi_lock_ctrl_bench.sv
module smi_lock_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int EN_W       = 16;
    localparam int GBL_BIT    = 3;
    localparam int CFG_W      = 8;
    localparam int LOCK_BIT   = 2;
    localparam logic [EN_W-1:0]  GSEL = 16'h0008;
    localparam logic [CFG_W-1:0] LSEL = 8'h04;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_we = 1'b0, en_re = 1'b0, cfg_we = 1'b0, cfg_re = 1'b0;
    logic [EN_W-1:0]  en_wdata = '0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             en_rvalid, cfg_rvalid, lock_o;
    logic [EN_W-1:0]  en_rdata, smi_en_o;
    logic [CFG_W-1:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [EN_W-1:0]  m_en;
    logic [CFG_W-1:0] m_cfg;

    logic [EN_W-1:0]  en_exp[$];
    string            en_tag[$];
    logic [CFG_W-1:0] cfg_exp[$];
    string            cfg_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_lock_ctrl #(
        .EN_W(EN_W), .GBL_BIT(GBL_BIT), .EN_RST('0),
        .CFG_W(CFG_W), .LOCK_BIT(LOCK_BIT)
    ) u_smi_lock_ctrl (
        .clk(clk), .rst_n(rst_n),
        .en_we(en_we), .en_wdata(en_wdata), .en_re(en_re),
        .en_rvalid(en_rvalid), .en_rdata(en_rdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_re(cfg_re),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .smi_en_o(smi_en_o), .lock_o(lock_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock of stimulus; compares outputs to the model first
    task automatic cyc(input string req,
                       input logic ew, input logic [EN_W-1:0] ed, input logic er,
                       input logic cw, input logic [CFG_W-1:0] cd, input logic cr);
        @(negedge clk);
        check({req, " smi_en_o"}, 32'(smi_en_o), 32'(m_en));
        check({req, " lock_o"}, 32'(lock_o), 32'(m_cfg[LOCK_BIT]));
        en_we = ew; en_wdata = ed; en_re = er;
        cfg_we = cw; cfg_wdata = cd; cfg_re = cr;
        if (er) begin en_exp.push_back(m_en); en_tag.push_back(req); end
        if (cr) begin cfg_exp.push_back(m_cfg); cfg_tag.push_back(req); end
        if (ew) begin
            if (m_cfg[LOCK_BIT]) m_en = (ed & ~GSEL) | (m_en & GSEL);
            else                 m_en = ed;
        end
        if (cw) m_cfg = (cd & ~LSEL) | ((cd | m_cfg) & LSEL);
    endtask

    task automatic idle(input string req);
        cyc(req, 1'b0, '0, 1'b1, 1'b0, '0, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en_we = 0; en_re = 0; cfg_we = 0; cfg_re = 0;
        m_en = '0; m_cfg = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && en_rvalid) begin
                if (en_exp.size() == 0) check("R8 unexpected en_rvalid", 1, 0);
                else check({en_tag.pop_front(), " en_rdata"}, 32'(en_rdata), 32'(en_exp.pop_front()));
            end
            if (rst_n && cfg_rvalid) begin
                if (cfg_exp.size() == 0) check("R8 unexpected cfg_rvalid", 1, 0);
                else check({cfg_tag.pop_front(), " cfg_rdata"}, 32'(cfg_rdata), 32'(cfg_exp.pop_front()));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_en = '0; m_cfg = '0;
        do_reset();
        idle("R1");
        // R2 open mask
        cyc("R2", 1, 16'hFFFF, 0, 0, '0, 0);
        idle("R2");
        cyc("R2", 1, 16'h5A52, 1, 0, '0, 0);   // R8: read in write cycle sees old value
        idle("R2");
        cyc("R2", 1, 16'h0000, 0, 0, '0, 0);
        idle("R2");
        // R9 writing 0 to the clear lock
        cyc("R9", 0, '0, 0, 1, 8'hF3, 0);
        idle("R9");
        // R7 lock set and global bit written in the same cycle
        cyc("R7", 1, 16'h0008, 0, 1, 8'h04, 1);
        idle("R3");
        // R4 clear attempt, R6 other bits
        cyc("R4", 1, 16'h1230, 0, 0, '0, 0);
        idle("R4");
        cyc("R6", 1, 16'hFFF7, 0, 0, '0, 0);
        idle("R6");
        // R5 lock stays, other cfg bits writable
        cyc("R5", 0, '0, 0, 1, 8'h00, 0);
        idle("R5");
        cyc("R5", 0, '0, 0, 1, 8'hA9, 0);
        idle("R5");
        // R10 reset reopens
        do_reset();
        idle("R10");
        cyc("R10", 1, 16'h0008, 0, 0, '0, 0);
        idle("R10");
        cyc("R10", 1, 16'h0000, 0, 0, '0, 0);
        idle("R10");
        // lock with global bit clear, then try to set it (R4)
        cyc("R3", 0, '0, 0, 1, 8'h04, 0);
        idle("R3");
        cyc("R4", 1, 16'hFFFF, 0, 0, '0, 0);
        idle("R4");
        cyc("R8", 1, 16'h0101, 1, 1, 8'h10, 1);
        idle("R8");
        idle("R8");
        @(negedge clk);
        check("R8 en queue drained", 32'(en_exp.size()), 0);
        check("R8 cfg queue drained", 32'(cfg_exp.size()), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule